// File: doc/BRIEF.md
# Page-Mode Write Load Controller

This block models the write path of a page-programmed nonvolatile memory as a synchronous design. It samples the active-low chip enable, write enable and output enable on a fast system clock. A write strobe exists while chip enable and write enable are both low and output enable is high. Each strobe loads one byte into a page buffer. The address is taken when the strobe begins, which is the later of the two enables falling. The data is taken when the strobe ends, which is the first of the two enables rising. Bytes of the page may arrive in any order.

After each strobe ends, a gap counter starts. A new strobe that begins before the gap limit is reached keeps the load window open. When the limit expires, the whole buffered page is written into a behavioural storage array in one step. A fixed programming period then follows. During that period a read returns a polling word, not array data: bit 7 is the inverse of bit 7 of the last accepted byte, and bits 6..0 are zero. The first load of a window fixes the page. A later load to a different page in the same window is dropped, and it sets a sticky error flag.

The address is split into a page field, `addr[ADDR_W-1:6]`, and a byte offset, `addr[5:0]`. The default `ADDR_W` of 10 gives 16 pages of 64 bytes each. Storage resets to 8'hFF. Bytes of a page that were not loaded in its window become undefined.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset, `dout_en` and `page_err` are 0, and every array byte reads 8'hFF.
- R2: `dout_en` is 1 exactly when, on the previous clock, `ce_n` = 0, `oe_n` = 0 and `we_n` = 1. While `dout_en` is 0, `dout` is 8'h00.
- R3: The byte address of a load is the value on `addr` when the strobe starts, which is the later of `ce_n` and `we_n` falling. The stored data is the value on `din` when the strobe ends, which is the first of `ce_n` and `we_n` rising. Changes to `addr` before the start or during the strobe have no effect.
- R4: While `oe_n` = 0, a cycle with `ce_n` and `we_n` both low loads nothing and does not open a load window.
- R5: When the load window expires, every byte loaded in that window is written to `{page, offset}` in the array at the same time, whatever order the bytes were loaded in.
- R6: A strobe that begins within `WIN_CYC` cycles of the end of the previous strobe keeps the window open. While the window is open, reads return the old array contents.
- R7: For `PROG_CYC` cycles after the window expires, a read returns `{~b7, 7'b0}`, where b7 is bit 7 of the last accepted byte. Once that period ends, reads return array data again.
- R8: A load whose page differs from the page of the first load in the window is not written, and it sets `page_err`. `page_err` then stays 1 until reset.
- R9: Strobes that begin during the programming period load nothing and do not start a new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; the top bits select the page and the low 6 bits select the offset |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or polling word; 0 when not driven |
| dout_en | output | 1 | Data output is driven |
| page_err | output | 1 | Sticky flag for a load to the wrong page |

## Verification
The inputs are registered once, so `dout` and `dout_en` follow an input change after one clock edge. The bench drives inputs on the falling clock edge. A scoreboard entry is due one cycle after it is pushed and is compared on the next falling edge.

A load is written only when its window times out, which is about `WIN_CYC` cycles after the last strobe ends. The polling period then lasts `PROG_CYC` cycles. Because the exact edge of each timeout depends on the strobe synchronisation, checks that test for open-window data, polling words or programmed data are placed at least 50 cycles clear of each edge. `page_err` is checked a few cycles after the offending strobe has ended.

// File: rtl/wl_pkg.sv
package wl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PROG
    } wl_state_e;

    typedef struct packed {
        logic act;
        logic fall;
        logic rise;
    } wl_ev_t;

    function automatic logic wr_cond(input logic ce_n, input logic we_n, input logic oe_n);
        return !ce_n && !we_n && oe_n;
    endfunction

    function automatic logic rd_cond(input logic ce_n, input logic we_n, input logic oe_n);
        return !ce_n && !oe_n && we_n;
    endfunction

    function automatic logic [7:0] poll_word(input logic last_b7);
        return {~last_b7, 7'b0};
    endfunction

endpackage

// File: rtl/wl_strobe.sv
module wl_strobe
    import wl_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output wl_ev_t            ev,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [7:0]        ld_data,
    output logic              rd,
    output logic [ADDR_W-1:0] rd_addr
);
    logic              s_ce, s_we, s_oe, act_q;
    logic [ADDR_W-1:0] s_addr, addr_q;
    logic [7:0]        s_din;
    logic              act;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_ce   <= 1'b1;
            s_we   <= 1'b1;
            s_oe   <= 1'b1;
            s_addr <= '0;
            s_din  <= '0;
            act_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            s_ce   <= ce_n;
            s_we   <= we_n;
            s_oe   <= oe_n;
            s_addr <= addr;
            s_din  <= din;
            act_q  <= act;
            if (act && !act_q)
                addr_q <= s_addr;
        end
    end

    always_comb begin
        act     = wr_cond(s_ce, s_we, s_oe);
        ev.act  = act;
        ev.fall = act && !act_q;
        ev.rise = !act && act_q;
        ld_addr = ev.fall ? s_addr : addr_q;
        ld_data = s_din;
        rd      = rd_cond(s_ce, s_we, s_oe);
        rd_addr = s_addr;
    end

    // R2
    read_enable_chk: assert property (@(posedge clk) disable iff (rst)
        rd == $past(!ce_n && !oe_n && we_n));

endmodule

// File: rtl/wl_ctrl.sv
module wl_ctrl
    import wl_pkg::*;
#(
    parameter int PAGE_W   = 4,
    parameter int WIN_CYC  = 150,
    parameter int PROG_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  wl_ev_t            ev,
    input  logic [PAGE_W-1:0] ev_page,
    output logic              wr_en,
    output logic              commit,
    output logic [PAGE_W-1:0] cur_page,
    output logic              busy,
    output logic              page_err
);
    localparam int GW = $clog2(WIN_CYC + 1);
    localparam int PW = $clog2(PROG_CYC + 1);
    localparam logic [GW-1:0] GAP_LAST  = GW'(WIN_CYC - 1);
    localparam logic [PW-1:0] PROG_LAST = PW'(PROG_CYC - 1);

    wl_state_e   state;
    logic [GW-1:0] gap;
    logic [PW-1:0] pcnt;
    logic          skip;

    always_comb begin
        busy   = (state == ST_PROG);
        wr_en  = (state == ST_LOAD) && ev.rise && !skip;
        commit = (state == ST_LOAD) && !ev.fall && !ev.act && (gap == GAP_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            gap      <= '0;
            pcnt     <= '0;
            cur_page <= '0;
            skip     <= 1'b0;
            page_err <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ev.fall) begin
                        state    <= ST_LOAD;
                        cur_page <= ev_page;
                        skip     <= 1'b0;
                        gap      <= '0;
                    end
                end
                ST_LOAD: begin
                    if (ev.fall) begin
                        gap <= '0;
                        if (ev_page != cur_page) begin
                            skip     <= 1'b1;
                            page_err <= 1'b1;
                        end else begin
                            skip <= 1'b0;
                        end
                    end else if (!ev.act) begin
                        if (gap == GAP_LAST) begin
                            state <= ST_PROG;
                            pcnt  <= '0;
                        end else begin
                            gap <= gap + GW'(1);
                        end
                    end
                end
                default: begin
                    if (pcnt == PROG_LAST)
                        state <= ST_IDLE;
                    else
                        pcnt <= pcnt + PW'(1);
                end
            endcase
        end
    end

    // R6
    gap_window_chk: assert property (@(posedge clk) disable iff (rst)
        gap < GW'(WIN_CYC));

    // R5
    commit_enter_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> busy);

    // R8
    page_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(page_err) |-> page_err);

    // R8
    page_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(page_err) |-> $past(ev.fall));

endmodule

// File: rtl/wl_store.sv
module wl_store
    import wl_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 64
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  wr_en,
    input  logic [$clog2(PAGE_BYTES)-1:0]         wr_idx,
    input  logic [7:0]                            wr_data,
    input  logic                                  commit,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]  commit_page,
    input  logic                                  busy,
    input  logic                                  rd,
    input  logic [ADDR_W-1:0]                     rd_addr,
    output logic [7:0]                            dout,
    output logic                                  dout_en
);
    localparam int OFF_W     = $clog2(PAGE_BYTES);
    localparam int NUM_BYTES = 1 << ADDR_W;

    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask;
    logic                  last_b7;
    logic [7:0]            mem  [NUM_BYTES];

    always_ff @(posedge clk) begin
        if (wr_en)
            pbuf[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask    <= '0;
            last_b7 <= 1'b0;
            for (int i = 0; i < NUM_BYTES; i++)
                mem[i] <= 8'hFF;
        end else begin
            if (wr_en) begin
                mask[wr_idx] <= 1'b1;
                last_b7      <= wr_data[7];
            end
            if (commit) begin
                for (int i = 0; i < PAGE_BYTES; i++)
                    mem[{commit_page, OFF_W'(i)}] <= mask[i] ? pbuf[i] : 8'hxx;
                mask <= '0;
            end
        end
    end

    always_comb begin
        dout_en = rd;
        if (!rd)
            dout = 8'h00;
        else if (busy)
            dout = poll_word(last_b7);
        else
            dout = mem[rd_addr];
    end

    // R9
    mask_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mask));

endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
    import wl_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 64,
    parameter int WIN_CYC    = 150,
    parameter int PROG_CYC   = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              page_err
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;

    wl_ev_t            ev;
    logic [ADDR_W-1:0] ld_addr, rd_addr;
    logic [7:0]        ld_data;
    logic              rd, wr_en, commit, busy;
    logic [PAGE_W-1:0] cur_page;

    wl_strobe #(.ADDR_W(ADDR_W)) u_strobe (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .ev(ev), .ld_addr(ld_addr),
        .ld_data(ld_data), .rd(rd), .rd_addr(rd_addr)
    );

    wl_ctrl #(.PAGE_W(PAGE_W), .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)) u_ctrl (
        .clk(clk), .rst(rst), .ev(ev), .ev_page(ld_addr[ADDR_W-1:OFF_W]),
        .wr_en(wr_en), .commit(commit), .cur_page(cur_page),
        .busy(busy), .page_err(page_err)
    );

    wl_store #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(ld_addr[OFF_W-1:0]),
        .wr_data(ld_data), .commit(commit), .commit_page(cur_page),
        .busy(busy), .rd(rd), .rd_addr(rd_addr),
        .dout(dout), .dout_en(dout_en)
    );

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> (dout == 8'h00));

endmodule

// File: tb/sim_page_load_ctrl.sv
`timescale 1ns/1ps
module sim_page_load_ctrl;
    localparam int AW   = 10;
    localparam int WIN  = 150;
    localparam int PROG = 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic dout_en, page_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int         due;
        logic       en;
        logic [7:0] d;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    page_load_ctrl #(.ADDR_W(AW), .PAGE_BYTES(64), .WIN_CYC(WIN), .PROG_CYC(PROG)) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .page_err(page_err)
    );

    function automatic logic [AW-1:0] pa(input int page, input int off);
        return AW'(page * 64 + off);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic en, input logic [7:0] d, input string tag);
        exp_t e;
        e.due = cyc + 1;
        e.en  = en;
        e.d   = d;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            check(dout_en === e.en, {e.tag, " dout_en"}, int'(dout_en), int'(e.en));
            check(dout === e.d, {e.tag, " dout"}, int'(dout), int'(e.d));
        end
    end

    task automatic rd_exp(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        push(1'b1, d, tag);
        tick(1);
        ce_n = 1'b1; oe_n = 1'b1;
        push(1'b0, 8'h00, {tag, " release"});
        tick(1);
    endtask

    task automatic load_both(input logic [AW-1:0] a, input logic [7:0] d);
        addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        tick(3);
        ce_n = 1'b1; we_n = 1'b1;
        tick(2);
    endtask

    task automatic load_we_late(input logic [AW-1:0] a, input logic [7:0] d);
        oe_n = 1'b1; ce_n = 1'b0; addr = '1; din = 8'h5A;
        tick(2);
        addr = a; din = d; we_n = 1'b0;
        tick(2);
        we_n = 1'b1;
        tick(1);
        ce_n = 1'b1; addr = '1;
        tick(2);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        // R1 reset state
        check(dout_en === 1'b0, "R1 dout_en after reset", int'(dout_en), 0);
        check(page_err === 1'b0, "R1 page_err after reset", int'(page_err), 0);
        rd_exp(pa(0, 5), 8'hFF, "R1 erased byte");
        rd_exp(pa(9, 63), 8'hFF, "R1 erased byte top");

        // R2 read needs oe low and we high
        addr = pa(0, 5); ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        push(1'b0, 8'h00, "R2 oe high");
        tick(1);
        ce_n = 1'b1; oe_n = 1'b0;
        push(1'b0, 8'h00, "R2 ce high");
        tick(1);
        oe_n = 1'b1;

        // R4 strobe with oe low loads nothing
        addr = pa(1, 7); din = 8'h00; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        push(1'b0, 8'h00, "R4 oe low strobe no drive");
        tick(3);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        tick(WIN + 60);
        rd_exp(pa(1, 7), 8'hFF, "R4 no load and no poll");

        // R3 R5 R6 page 2, mixed order and strobe styles
        load_both(pa(2, 10), 8'hA5);
        tick(20);
        load_we_late(pa(2, 3), 8'h3C);
        tick(100);
        rd_exp(pa(2, 10), 8'hFF, "R6 open window old data");
        tick(10);
        addr = pa(2, 20); din = 8'h11; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        tick(2);
        addr = pa(2, 21); din = 8'h99;
        tick(2);
        ce_n = 1'b1; we_n = 1'b1;
        tick(20);
        load_both(pa(2, 63), 8'hC3);
        tick(20);
        load_both(pa(2, 0), 8'h81);
        tick(250);
        // R7 poll of last byte 0x81
        rd_exp(pa(2, 10), 8'h00, "R7 poll inverted bit7");
        // R9 strobe during programming
        load_both(pa(5, 1), 8'h42);
        tick(1250);
        rd_exp(pa(2, 10), 8'hA5, "R5 programmed off10");
        rd_exp(pa(2, 3), 8'h3C, "R3 late we strobe");
        rd_exp(pa(2, 20), 8'h99, "R3 addr at start data at end");
        rd_exp(pa(2, 63), 8'hC3, "R5 programmed off63");
        rd_exp(pa(2, 0), 8'h81, "R5 programmed off0");
        rd_exp(pa(5, 1), 8'hFF, "R9 load in program ignored");
        tick(WIN + 60);
        rd_exp(pa(5, 1), 8'hFF, "R9 no new window");
        check(page_err === 1'b0, "R8 no error yet", int'(page_err), 0);

        // R8 page mismatch
        load_both(pa(3, 0), 8'h12);
        tick(10);
        load_both(pa(4, 0), 8'h34);
        tick(3);
        check(page_err === 1'b1, "R8 mismatch sets flag", int'(page_err), 1);
        load_both(pa(3, 1), 8'h56);
        tick(250);
        rd_exp(pa(3, 0), 8'h80, "R7 poll of 0x56");
        tick(1250);
        rd_exp(pa(3, 0), 8'h12, "R8 first page byte");
        rd_exp(pa(3, 1), 8'h56, "R8 load after mismatch");
        rd_exp(pa(4, 0), 8'hFF, "R8 mismatched byte dropped");
        check(page_err === 1'b1, "R8 flag sticky", int'(page_err), 1);
        tick(3);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule